// File: doc/BRIEF.md
# Threshold-Gated Burst DMA Mover

This block carries out one block move between an external FIFO and a bus-master port. Software or a sequencer supplies a byte count, a start address, a direction and a burst size, then pulses `start`. The mover splits the move into bursts. Before each burst it waits until the FIFO can supply a whole burst (toward memory) or can accept a whole burst (from memory). It then requests the bus, runs one burst once the grant arrives, and gives the bus back. It advances its address and remaining count, and repeats until nothing is left. It then pulses `done`. If the bus reports an error on a beat, the move stops and `error` pulses instead.

The FIFO storage is outside the block and is seen only through two level inputs, counted in 4-byte words. The data beats use a valid/ready handshake. `beat_valid` is high for every beat of the current burst until that beat is accepted. The bus side may hold `beat_ready` low for any number of cycles to apply back-pressure, and a beat counts only in a cycle where both are high. The mover never withdraws `beat_valid` in the middle of a burst. Request and grant are plain level signals. `bus_addr` and `bus_len` describe the burst and stay constant from the request until the last beat.

Top module: `burst_dma_mover`

## Requirements
- R1: While reset is held and after it is released, `bus_req`, `beat_valid`, `busy`, `done` and `error` are low until a move is started.
- R2: A `start` pulse while idle captures the count, address, direction and burst size. `burst_sel` maps as 0 to 4, 1 to 8, 2 to 16 and 3 to 32 words. The two low bits of `byte_count` are ignored. A `start` pulse while `busy` is high is ignored and does not change the move in progress.
- R3: With `to_mem` = 1, a burst is requested only once `fifo_level` is at least the burst length in words.
- R4: With `to_mem` = 0, a burst is requested only once `fifo_space` is at least the burst length in words.
- R5: After a grant, the burst moves exactly `bus_len` beats, one per cycle in which `beat_valid` and `beat_ready` are both high. `beat_valid` first rises in the cycle after the grant is accepted.
- R6: `bus_req` stays high from its rise until the cycle in which `bus_gnt` is seen. It then falls and stays low for the whole burst.
- R7: Each following burst starts at the previous burst's address plus 4 bytes per beat moved, and the remaining count drops by the same amount. Between bursts the bus is not requested until the FIFO condition holds again.
- R8: When fewer words remain than one burst, the final burst is shortened to the remaining words, and its FIFO condition compares against that shorter length.
- R9: `done` is a one-cycle pulse in the cycle after the final beat's handshake, and `busy` is low with it.
- R10: A count below 4 bytes completes with a `done` pulse in the cycle after `start`, with no bus request.
- R11: `bus_err` high during an accepted beat aborts the move. `error` pulses for one cycle, `done` does not pulse, and no further beat or request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (idle only) |
| to_mem | input | 1 | 1: FIFO to memory, 0: memory to FIFO |
| byte_count | input | 24 | Bytes to move (low two bits ignored) |
| start_addr | input | 32 | First memory byte address |
| burst_sel | input | 2 | Burst size select: 4 << burst_sel words |
| fifo_level | input | 7 | Words currently held in the FIFO |
| fifo_space | input | 7 | Words of free room in the FIFO |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 32 | Start address of the current burst |
| bus_len | output | 6 | Beats in the current burst |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat accepted by the bus |
| bus_err | input | 1 | Error on the accepted beat |
| busy | output | 1 | Move in progress |
| done | output | 1 | Move completed (pulse) |
| error | output | 1 | Move aborted (pulse) |

## Verification
The assertions assume that the level inputs report the FIFO truthfully and that the FIFO is at least as deep as the largest burst. They also assume that `beat_ready` and `bus_err` matter only while `beat_valid` is high, and that a grant answers a request. The bench's bus responder follows these rules. It raises `bus_gnt` only after it has seen `bus_req` for a chosen delay. It drives `beat_ready` only while a beat is offered, and it raises `bus_err` only together with an accepted beat. The bench sets the FIFO levels directly. It starts them below the threshold and then moves them to exactly the threshold, so the gating boundary is crossed without faking a FIFO that overflows.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  localparam int BEAT_BYTES = 4;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER
  } mover_state_e;
endpackage

// File: rtl/dma_gate.sv
module dma_gate #(
  parameter int REM_W = 24,
  parameter int LEN_W = 6,
  parameter int LVL_W = 7
) (
  input  logic [REM_W-1:0] rem_beats,
  input  logic [LEN_W-1:0] burst_beats,
  input  logic             to_mem,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] fifo_space,
  output logic [LEN_W-1:0] need,
  output logic             ok
);
  logic [LVL_W-1:0] have;

  always_comb begin
    if (rem_beats < REM_W'(burst_beats)) need = rem_beats[LEN_W-1:0];
    else                                 need = burst_beats;
    have = to_mem ? fifo_level : fifo_space;
    ok   = (need != '0) && (have >= LVL_W'(need));
  end
endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + LEN_W'(1);
  end

  assign last = step && (cnt == len - LEN_W'(1));

  // R5
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt < len));
endmodule

// File: rtl/burst_dma_mover.sv
module burst_dma_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int FIFO_DEPTH = 64,
  parameter int MIN_BURST  = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic                                     to_mem,
  input  logic [CNT_W-1:0]                         byte_count,
  input  logic [ADDR_W-1:0]                        start_addr,
  input  logic [1:0]                               burst_sel,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]          fifo_level,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]          fifo_space,
  output logic                                     bus_req,
  input  logic                                     bus_gnt,
  output logic [ADDR_W-1:0]                        bus_addr,
  output logic [$clog2((MIN_BURST << 3) + 1)-1:0]  bus_len,
  output logic                                     beat_valid,
  input  logic                                     beat_ready,
  input  logic                                     bus_err,
  output logic                                     busy,
  output logic                                     done,
  output logic                                     error
);
  localparam int MAX_BURST = MIN_BURST << 3;
  localparam int LEN_W     = $clog2(MAX_BURST + 1);
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1);

  mover_state_e      state;
  logic [CNT_W-1:0]  rem;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  len_r;
  logic [LEN_W-1:0]  burst_beats;
  logic [LEN_W-1:0]  need;
  logic [1:0]        sel_r;
  logic              to_mem_r;
  logic              gate_ok;
  logic              hs;
  logic              last_beat;
  logic              done_q;
  logic              err_q;

  assign burst_beats = LEN_W'(MIN_BURST) << sel_r;
  assign hs          = (state == ST_XFER) && beat_ready;

  dma_gate #(.REM_W(CNT_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_gate (
    .rem_beats  (rem),
    .burst_beats(burst_beats),
    .to_mem     (to_mem_r),
    .fifo_level (fifo_level),
    .fifo_space (fifo_space),
    .need       (need),
    .ok         (gate_ok)
  );

  dma_beat_ctr #(.LEN_W(LEN_W)) u_beats (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(state == ST_REQ),
    .step (hs),
    .len  (len_r),
    .last (last_beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rem      <= '0;
      addr     <= '0;
      len_r    <= '0;
      sel_r    <= '0;
      to_mem_r <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          to_mem_r <= to_mem;
          sel_r    <= burst_sel;
          addr     <= start_addr;
          rem      <= byte_count >> BEAT_SHIFT;
          if ((byte_count >> BEAT_SHIFT) == '0) done_q <= 1'b1;
          else                                  state  <= ST_WAIT;
        end
        ST_WAIT: if (gate_ok) begin
          len_r <= need;
          state <= ST_REQ;
        end
        ST_REQ: if (bus_gnt) state <= ST_XFER;
        ST_XFER: begin
          if (hs && bus_err) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end else if (last_beat) begin
            rem  <= rem - CNT_W'(len_r);
            addr <= addr + ADDR_W'({len_r, {BEAT_SHIFT{1'b0}}});
            if (rem == CNT_W'(len_r)) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req    = (state == ST_REQ);
  assign beat_valid = (state == ST_XFER);
  assign bus_addr   = addr;
  assign bus_len    = len_r;
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign error      = err_q;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R5
  beat_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> $past(bus_req && bus_gnt));

  // R3 and R4
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(gate_ok));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_len != '0 && bus_len <= burst_beats));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && !done && !beat_valid));
endmodule

// File: tb/burst_dma_mover_test.sv
module burst_dma_mover_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_mem = 1'b1;
  logic [23:0] byte_count = '0;
  logic [31:0] start_addr = '0;
  logic [1:0]  burst_sel = '0;
  logic [6:0]  fifo_level = 7'd64;
  logic [6:0]  fifo_space = 7'd64;
  logic        bus_req, bus_gnt, beat_valid, beat_ready, bus_err;
  logic [31:0] bus_addr;
  logic [5:0]  bus_len;
  logic        busy, done, error;

  always #2 clk = ~clk;

  burst_dma_mover uut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
    .byte_count(byte_count), .start_addr(start_addr), .burst_sel(burst_sel),
    .fifo_level(fifo_level), .fifo_space(fifo_space),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_len(bus_len),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .bus_err(bus_err),
    .busy(busy), .done(done), .error(error)
  );

  int errs = 0, checks = 0;
  int gnt_delay = 0, gcnt = 0, err_at = 0;
  bit stall = 0;
  int nlog = 0, total_beats = 0, ndone = 0, nerr = 0, req_cyc = 0;
  logic [31:0] log_addr [16];
  int          log_len  [16];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bus responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 0; beat_ready = 0; bus_err = 0; gcnt = 0;
    end else begin
      bus_err = 0;
      if (done)  ndone++;
      if (error) nerr++;
      if (bus_req && !bus_gnt) begin
        req_cyc++;
        if (gcnt >= gnt_delay) begin
          bus_gnt = 1; gcnt = 0;
          if (nlog < 16) begin log_addr[nlog] = bus_addr; log_len[nlog] = int'(bus_len); end
          nlog++;
        end else gcnt++;
      end else bus_gnt = 0;
      if (beat_valid) begin
        beat_ready = stall ? ~beat_ready : 1'b1;
        if (beat_ready) begin
          total_beats++;
          if (err_at == total_beats) bus_err = 1;
        end
      end else beat_ready = 0;
    end
  end

  task automatic clear_logs();
    nlog = 0; total_beats = 0; ndone = 0; nerr = 0; req_cyc = 0;
    err_at = 0; stall = 0; gnt_delay = 0;
  endtask

  task automatic go(bit dir, int cnt, logic [31:0] a, int sel);
    @(negedge clk);
    to_mem = dir; byte_count = 24'(cnt); start_addr = a; burst_sel = 2'(sel);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (!done && !error && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 bus_req", bus_req, 0);
    chk("R1 beat_valid", beat_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
  endtask

  task automatic t_zero();
    clear_logs();
    go(1, 3, 32'h40, 0);
    chk("R10 done next cycle", done, 1);
    wait_end();
    chk("R10 done count", ndone, 1);
    chk("R10 no request", nlog, 0);
    chk("R10 busy low", busy, 0);
  endtask

  task automatic t_rx_full();
    clear_logs(); gnt_delay = 3; fifo_level = 64;
    go(1, 64, 32'h1000, 1);
    repeat (5) @(negedge clk);
    byte_count = 24'd400; burst_sel = 2'd0; start = 1;
    @(negedge clk); start = 0;
    wait_end();
    chk("R2 start while busy ignored, bursts", nlog, 2);
    chk("R5 len0", log_len[0], 8);
    chk("R5 len1", log_len[1], 8);
    chk("R5 addr0", log_addr[0], 32'h1000);
    chk("R7 addr1", log_addr[1], 32'h1020);
    chk("R5 beats", total_beats, 16);
    chk("R6 request cycles", req_cyc, 8);
    chk("R9 done once", ndone, 1);
    repeat (3) @(negedge clk);
    chk("R2 no restart", busy, 0);
  endtask

  task automatic t_tx_short();
    clear_logs(); stall = 1; fifo_level = 0; fifo_space = 64;
    go(0, 42, 32'h2000, 0);
    wait_end();
    chk("R2 low bits ignored, beats", total_beats, 10);
    chk("R8 bursts", nlog, 3);
    chk("R8 short len", log_len[2], 2);
    chk("R7 addr1", log_addr[1], 32'h2010);
    chk("R7 addr2", log_addr[2], 32'h2020);
    chk("R9 done", ndone, 1);
  endtask

  task automatic t_gate_rx();
    clear_logs(); fifo_level = 15;
    go(1, 64, 32'h3000, 2);
    repeat (20) @(negedge clk);
    chk("R3 no request below threshold", req_cyc, 0);
    chk("R3 still busy", busy, 1);
    fifo_level = 16;
    wait_end();
    chk("R3 burst after threshold", nlog, 1);
    chk("R3 len", log_len[0], 16);
    chk("R9 done", ndone, 1);
    fifo_level = 64;
  endtask

  task automatic t_gate_tx_short();
    clear_logs(); fifo_space = 5;
    go(0, 24, 32'h4000, 3);
    repeat (20) @(negedge clk);
    chk("R4 no request below reduced threshold", req_cyc, 0);
    fifo_space = 6;
    wait_end();
    chk("R8 single short burst", nlog, 1);
    chk("R8 len", log_len[0], 6);
    chk("R9 done", ndone, 1);
    fifo_space = 64;
  endtask

  task automatic t_between();
    clear_logs(); fifo_level = 64;
    go(1, 32, 32'h5000, 0);
    while (nlog < 1) @(negedge clk);
    while (!beat_valid) @(negedge clk);
    while (beat_valid) @(negedge clk);
    fifo_level = 3;
    repeat (15) @(negedge clk);
    chk("R7 bus off between bursts", nlog, 1);
    chk("R7 req low", bus_req, 0);
    fifo_level = 4;
    wait_end();
    chk("R7 second burst", nlog, 2);
    chk("R7 addr1", log_addr[1], 32'h5010);
    fifo_level = 64;
  endtask

  task automatic t_err();
    int rc;
    clear_logs(); err_at = 6;
    go(1, 64, 32'h6000, 0);
    wait_end();
    chk("R11 error pulse", nerr, 1);
    chk("R11 no done", ndone, 0);
    chk("R11 beats", total_beats, 6);
    rc = req_cyc;
    repeat (10) @(negedge clk);
    chk("R11 no further request", req_cyc, rc);
    chk("R11 no further beats", total_beats, 6);
    chk("R11 idle", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_rx_full();
    t_tx_short();
    t_gate_rx();
    t_gate_tx_short();
    t_between();
    t_err();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule